// File: doc/BRIEF.md
# Display Memory Write Contention Guard

This block sits between a CPU bus and a dual-port video RAM. The other port of the RAM is read without pause by a display generator. The RAM raises an active-low wait on each port when both ports touch the same cell at once.

On each CPU memory write into the video window, the guard samples the combined wait state. If a collision is reported, it drives the display-side chip select inactive until the CPU write strobe goes high again. The CPU write is therefore never dropped, and the display loses the port for that one write cycle only.

The guard also holds a two-bit mode register for the display generator. The register is loaded from the data bus when the CPU writes to a single decoded address.

The design runs on a fast system clock. The bus strobes and the wait lines pass through two-flop synchronizers, and the write-strobe edges are detected from the synchronized copy. Address and data are sampled directly, because the bus keeps them stable for the whole write.

Top module: `vram_guard`

## Requirements
- R1: After reset, `disp_cs_n` is 0 (display port selected), `mode` is 2'b00 and `coll_pulse` is 0.
- R2: A collision is seen when either `wait_l_n` or `wait_r_n` is low, that is, when their AND is 0. With both waits high, a write leaves `disp_cs_n` at 0.
- R3: The collision state is sampled on the synchronized falling edge of `cpu_wr_n` while `cpu_mreq_n` is low. The result appears at the outputs on the third rising clock edge after `cpu_wr_n` falls.
- R4: A write whose address lies outside [WIN_BASE, WIN_BASE+WIN_SIZE) never changes `disp_cs_n`. Neither does a write strobe while `cpu_mreq_n` is high.
- R5: A colliding write inside the window drives `disp_cs_n` to 1. It stays at 1 while `cpu_wr_n` remains low, even if the wait lines return high.
- R6: `disp_cs_n` returns to 0 on the third rising clock edge after `cpu_wr_n` rises, whatever value was captured.
- R7: `mode` loads `cpu_data` on a write with `cpu_mreq_n` low to address MODE_ADDR. On every other write it holds its value, and the wait lines have no effect on it.
- R8: `coll_pulse` is high for exactly one clock for each write that was flagged as colliding, in the same cycle in which `disp_cs_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | ADDR_W | CPU address bus |
| cpu_data | input | 2 | The two data lines loaded into the mode register |
| cpu_wr_n | input | 1 | CPU write strobe, active low |
| cpu_mreq_n | input | 1 | CPU memory request, active low |
| wait_l_n | input | 1 | Left-port collision wait from the RAM, active low |
| wait_r_n | input | 1 | Right-port collision wait from the RAM, active low |
| disp_cs_n | output | 1 | Display-side RAM chip select, active low |
| mode | output | 2 | Display generator mode bits |
| coll_pulse | output | 1 | One-clock pulse per write flagged as colliding |

## Verification
Every registered result of this block is due on the third rising edge after the strobe change that causes it. Two edges are spent in the synchronizer and the third updates the output register. This holds for the chip-select assertion on a colliding write, its release after the strobe rises, the mode load and the collision pulse. The bench reference model keeps a four-deep history queue of the bus inputs and decides from the entries two and three edges old, so it predicts each output in the same cycle as the design. It compares at the falling clock edge, after the outputs have settled. Directed checks wait six cycles after a strobe change before sampling, which is well past the three-edge latency.

// File: rtl/vram_guard.sv
module vram_guard #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 16'h7000,
  parameter int                WIN_SIZE  = 2048,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 16'h6800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [1:0]        cpu_data,
  input  logic              cpu_wr_n,
  input  logic              cpu_mreq_n,
  input  logic              wait_l_n,
  input  logic              wait_r_n,
  output logic              disp_cs_n,
  output logic [1:0]        mode,
  output logic              coll_pulse
);

  localparam int                WIN_END   = int'(WIN_BASE) + WIN_SIZE;
  localparam logic [ADDR_W:0]   WIN_LO    = {1'b0, WIN_BASE};
  localparam logic [ADDR_W:0]   WIN_LIMIT = (ADDR_W+1)'(WIN_END);

  logic [3:0] meta, sync;
  logic       wr_s, mreq_s, wl_s, wr_wait_s, wr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 4'b1111;
      sync <= 4'b1111;
      wr_d <= 1'b1;
    end else begin
      meta <= {cpu_wr_n, cpu_mreq_n, wait_l_n, wait_r_n};
      sync <= meta;
      wr_d <= wr_s;
    end
  end

  assign wr_s      = sync[3];
  assign mreq_s    = sync[2];
  assign wl_s      = sync[1];
  assign wr_wait_s = sync[0];

  logic wr_fall, wr_rise, in_win, win_write, collide;

  assign wr_fall   = wr_d & ~wr_s;
  assign wr_rise   = ~wr_d & wr_s;
  assign in_win    = ({1'b0, cpu_addr} >= WIN_LO) && ({1'b0, cpu_addr} < WIN_LIMIT);
  assign win_write = wr_fall & ~mreq_s & in_win;
  assign collide   = ~(wl_s & wr_wait_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_cs_n  <= 1'b0;
      coll_pulse <= 1'b0;
      mode       <= 2'b00;
    end else begin
      coll_pulse <= win_write & collide;
      if (win_write)
        disp_cs_n <= collide;
      else if (wr_rise)
        disp_cs_n <= 1'b0;
      if (wr_fall && !mreq_s && cpu_addr == MODE_ADDR)
        mode <= cpu_data;
    end
  end

endmodule

// File: rtl/vram_guard_chk.sv
module vram_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_s,
  input logic       wr_d,
  input logic       disp_cs_n,
  input logic       coll_pulse,
  input logic [1:0] mode
);

  a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    coll_pulse |=> !coll_pulse);

  a_r8_pulse_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
    coll_pulse |-> disp_cs_n);

  a_r5_cs_rises_on_collision: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_cs_n) |-> coll_pulse);

  a_r6_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_s) |=> !disp_cs_n);

  a_r7_mode_on_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode) |-> !wr_d);

endmodule

bind vram_guard vram_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_s(wr_s), .wr_d(wr_d),
  .disp_cs_n(disp_cs_n), .coll_pulse(coll_pulse), .mode(mode)
);

// File: tb/vram_guard_tb_top.sv
module vram_guard_tb_top;

  localparam int WB = 28672;
  localparam int WS = 2048;
  localparam int MA = 26624;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [1:0]  cpu_data = '0;
  logic cpu_wr_n = 1'b1, cpu_mreq_n = 1'b1, wait_l_n = 1'b1, wait_r_n = 1'b1;
  logic disp_cs_n, coll_pulse;
  logic [1:0] mode;

  always #5 clk = ~clk;

  vram_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr_n(cpu_wr_n), .cpu_mreq_n(cpu_mreq_n), .wait_l_n(wait_l_n),
    .wait_r_n(wait_r_n), .disp_cs_n(disp_cs_n), .mode(mode), .coll_pulse(coll_pulse)
  );

  int checks = 0, errors = 0, cycles = 0, exp_colls = 0, seen_colls = 0;
  bit done = 0, model_ok = 0;

  logic [3:0] hist[$];
  bit   e_cs, e_pulse;
  logic [1:0] e_mode;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {4'hF, 4'hF, 4'hF, 4'hF};
      e_cs = 0; e_pulse = 0; e_mode = 2'b00;
    end else begin
      hist.push_front({cpu_wr_n, cpu_mreq_n, wait_l_n, wait_r_n});
      void'(hist.pop_back());
      begin
        bit fell, rose, req, win, col;
        fell = hist[3][3] && !hist[2][3];
        rose = !hist[3][3] && hist[2][3];
        req  = !hist[2][2];
        win  = (int'(cpu_addr) >= WB) && (int'(cpu_addr) < WB + WS);
        col  = !(hist[2][1] && hist[2][0]);
        e_pulse = fell && req && win && col;
        if (fell && req && win) e_cs = col;
        else if (rose) e_cs = 0;
        if (fell && req && int'(cpu_addr) == MA) e_mode = cpu_data;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n && model_ok) begin
      check(disp_cs_n == e_cs, "R5/R6 cs", disp_cs_n, e_cs);
      check(mode == e_mode, "R7 mode", mode, e_mode);
      check(coll_pulse == e_pulse, "R8 pulse", coll_pulse, e_pulse);
      if (coll_pulse) seen_colls++;
    end
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // One bus write: mreq drives the strobe request, wl/wr_w are the waits,
  // late_clear drops the waits back high halfway through the strobe.
  task automatic bus_write(logic [15:0] a, logic [1:0] d, bit mreq_on,
                           bit wl, bit wrw, bit late_clear, int expect_cs, string req);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_mreq_n = !mreq_on;
    wait_l_n = wl; wait_r_n = wrw;
    idle(2);
    cpu_wr_n = 0;
    idle(6);
    if (expect_cs >= 0) check(disp_cs_n == expect_cs[0], req, disp_cs_n, expect_cs);
    if (late_clear) begin
      wait_l_n = 1; wait_r_n = 1;
      idle(6);
      if (expect_cs >= 0) check(disp_cs_n == expect_cs[0], "R5 hold", disp_cs_n, expect_cs);
    end
    cpu_wr_n = 1;
    idle(6);
    check(disp_cs_n == 1'b0, "R6 release", disp_cs_n, 0);
    cpu_mreq_n = 1; wait_l_n = 1; wait_r_n = 1;
    idle(3);
  endtask

  initial begin
    idle(3);
    check(disp_cs_n == 0, "R1 cs", disp_cs_n, 0);
    check(mode == 2'b00, "R1 mode", mode, 0);
    check(coll_pulse == 0, "R1 pulse", coll_pulse, 0);
    rst_n = 1;
    model_ok = 1;
    idle(4);

    bus_write(16'h7000, 2'b01, 1, 1, 1, 0, 0, "R2 no collision");
    bus_write(16'h7000, 2'b01, 1, 0, 1, 0, 1, "R2 left wait");  exp_colls++;
    bus_write(16'h77FF, 2'b01, 1, 1, 0, 0, 1, "R3 right wait"); exp_colls++;
    bus_write(16'h7400, 2'b10, 1, 0, 0, 1, 1, "R5 held");       exp_colls++;
    bus_write(16'h7800, 2'b01, 1, 0, 0, 0, 0, "R4 above window");
    bus_write(16'h6FFF, 2'b01, 1, 0, 0, 0, 0, "R4 below window");
    bus_write(16'h7100, 2'b01, 0, 0, 0, 0, 0, "R4 mreq high");
    bus_write(16'h6800, 2'b11, 1, 0, 0, 0, 0, "R7 mode write");
    check(mode == 2'b11, "R7 load", mode, 3);
    bus_write(16'h6800, 2'b10, 0, 1, 1, 0, 0, "R7 no mreq");
    check(mode == 2'b11, "R7 hold", mode, 3);
    bus_write(16'h7001, 2'b00, 1, 0, 1, 0, 1, "R5 again");      exp_colls++;
    check(mode == 2'b11, "R7 unaffected", mode, 3);
    bus_write(16'h6800, 2'b10, 1, 1, 1, 0, 0, "R7 reload");
    check(mode == 2'b10, "R7 load2", mode, 2);
    for (int i = 0; i < 20; i++)
      begin
        bus_write(16'h7000 + 16'(i * 97), 2'(i), 1, i[0], i[1], 0, (i[0] && i[1]) ? 0 : 1, "R3 sweep");
        if (!(i[0] && i[1])) exp_colls++;
      end
    idle(4);
    check(seen_colls == exp_colls, "R8 count", seen_colls, exp_colls);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule